// File: doc/BRIEF.md
# AXI-Stream Hysteresis Flow Gate

This block is a single pipeline register for an AXI-Stream path that carries data and an end-of-packet flag. Its upstream ready also depends on a latched run/stop state. Two trigger inputs control that state. `stop_req` forces the gate to stop. `go_req` lets it run again.

In normal use the triggers come from the fill flags of a FIFO placed after the block. The high-water flag drives `stop_req` and the low-water flag drives `go_req`. Once the FIFO reaches its upper threshold, the upstream source is held off until the FIFO has drained to its lower threshold. The source then gets a whole burst of room at once, and ready does not toggle on every beat near the full mark.

The reset input is asynchronous and active-low, and its release is synchronised to the clock inside the block. After reset the gate is in the running state and the register is empty.

Top module: `axis_xon_gate`

## Requirements
- R1: While reset is active and in the first cycle after it releases, `m_valid` is 0, the gate is running and `s_ready` is 1.
- R2: A beat accepted upstream (`s_valid` and `s_ready` high at a rising edge) is presented on `m_valid`, `m_data` and `m_last` directly after that same edge. There is exactly one register stage of latency.
- R3: When `stop_req` is 1 at a rising edge, `s_ready` is 0 from that edge on.
- R4: When `go_req` is 1 and `stop_req` is 0 at a rising edge, the gate runs from that edge on. `s_ready` then equals the register's own ready.
- R5: In the stopped state, `s_ready` stays 0 whatever `m_ready` does, until a `go_req` trigger is seen. This includes the whole span in which a FIFO sits between its two thresholds.
- R6: When `go_req` and `stop_req` are both 1 at the same edge, the gate stops.
- R7: While `m_valid` is 1 and `m_ready` is 0, the output beat holds steady. A beat held when the gate stops is still delivered, exactly once.
- R8: In the running state, `s_ready` is 1 exactly when the register is empty or `m_ready` is 1.
- R9: Beats leave in the order they were accepted, with data and last flag unchanged. None is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| s_valid | input | 1 | Upstream beat valid |
| s_ready | output | 1 | Upstream ready, gated by the run/stop state |
| s_data | input | DATA_W | Upstream beat data |
| s_last | input | 1 | Upstream end-of-packet flag |
| m_valid | output | 1 | Downstream beat valid (registered) |
| m_ready | input | 1 | Downstream ready |
| m_data | output | DATA_W | Downstream beat data (registered) |
| m_last | output | 1 | Downstream end-of-packet flag (registered) |
| go_req | input | 1 | Run trigger (low-water flag) |
| stop_req | input | 1 | Stop trigger (high-water flag) |

## Verification
A trigger sampled at one rising edge takes effect on `s_ready` right after that edge. An accepted beat likewise shows on the master side right after the edge that took it. Every result is therefore due one cycle after its cause. The bench drives inputs and samples outputs just after each falling edge. At each sample it predicts the gate state for the next edge from the triggers it has just sampled. A queue-based scoreboard compares every delivered beat against the order of acceptance. A FIFO model with high and low thresholds closes the loop and confirms that ready stays low between the thresholds.

// File: rtl/axis_xg_pkg.sv
package axis_xg_pkg;

  typedef enum logic {
    GATE_STOP = 1'b0,
    GATE_RUN  = 1'b1
  } gate_e;

  // Stop request dominates a simultaneous run request.
  function automatic gate_e gate_next(input gate_e cur, input logic go, input logic stop);
    gate_e nxt;
    nxt = cur;
    if (stop)    nxt = GATE_STOP;
    else if (go) nxt = GATE_RUN;
    return nxt;
  endfunction

endpackage

// File: rtl/xg_rst_sync.sv
module xg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) chain_q[i] <= 1'b0;
          else         chain_q[i] <= 1'b1;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) chain_q[i] <= 1'b0;
          else         chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/xg_hyst_gate.sv
module xg_hyst_gate
  import axis_xg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go_req,
  input  logic stop_req,
  output logic run
);
  gate_e state_q;
  gate_e state_d;
  logic  state_en;

  always_comb begin
    state_d  = gate_next(state_q, go_req, stop_req);
    state_en = (state_d != state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= GATE_RUN;
    else if (state_en) state_q <= state_d;
  end

  assign run = (state_q == GATE_RUN);
endmodule

// File: rtl/xg_pipe_stage.sv
module xg_pipe_stage #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [DATA_W-1:0] up_data,
  input  logic              up_last,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [DATA_W-1:0] dn_data,
  output logic              dn_last
);
  localparam int PAYLOAD_W = DATA_W + 1;

  logic                 valid_q, valid_d;
  logic [PAYLOAD_W-1:0] pay_q, pay_d;
  logic                 load_en;

  always_comb begin
    up_ready = !valid_q || dn_ready;
    load_en  = up_valid && up_ready;
    pay_d    = {up_last, up_data};
    valid_d  = valid_q;
    if (load_en)       valid_d = 1'b1;
    else if (dn_ready) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  // Payload needs no reset: it is qualified by valid_q.
  always_ff @(posedge clk) begin
    if (load_en) pay_q <= pay_d;
  end

  assign dn_valid = valid_q;
  assign dn_data  = pay_q[DATA_W-1:0];
  assign dn_last  = pay_q[PAYLOAD_W-1];
endmodule

// File: rtl/axis_xon_gate.sv
module axis_xon_gate #(
  parameter int DATA_W     = 32,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_last,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              m_last,
  input  logic              go_req,
  input  logic              stop_req
);
  logic rst_sync_n;
  logic gate_run;
  logic stage_ready;
  logic stage_in_valid;

  xg_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  xg_hyst_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .go_req   (go_req),
    .stop_req (stop_req),
    .run      (gate_run)
  );

  assign stage_in_valid = s_valid && gate_run;
  assign s_ready        = stage_ready && gate_run;

  xg_pipe_stage #(.DATA_W(DATA_W)) u_stage (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .up_valid (stage_in_valid),
    .up_ready (stage_ready),
    .up_data  (s_data),
    .up_last  (s_last),
    .dn_valid (m_valid),
    .dn_ready (m_ready),
    .dn_data  (m_data),
    .dn_last  (m_last)
  );
endmodule

// File: rtl/xg_checker.sv
module xg_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              s_valid,
  input logic              s_ready,
  input logic [DATA_W-1:0] s_data,
  input logic              s_last,
  input logic              m_valid,
  input logic              m_ready,
  input logic [DATA_W-1:0] m_data,
  input logic              m_last,
  input logic              go_req,
  input logic              stop_req
);
  // R2
  one_stage_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready |=> m_valid && m_data == $past(s_data) && m_last == $past(s_last));

  // R3
  stop_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> !s_ready);

  // R4
  go_resumes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_req && !stop_req |=> run);

  // R5
  stop_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !go_req |=> !run && !s_ready);

  // R6
  stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_req && stop_req |=> !run);

  // R7
  held_beat_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_last));

  // R8
  full_backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |-> !s_ready);
endmodule

bind axis_xon_gate xg_checker #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .run      (gate_run),
  .s_valid  (s_valid),
  .s_ready  (s_ready),
  .s_data   (s_data),
  .s_last   (s_last),
  .m_valid  (m_valid),
  .m_ready  (m_ready),
  .m_data   (m_data),
  .m_last   (m_last),
  .go_req   (go_req),
  .stop_req (stop_req)
);

// File: tb/axis_xon_gate_tb.sv
module axis_xon_gate_tb;
  localparam int DW    = 32;
  localparam int DEPTH = 16;
  localparam int HI    = 12;
  localparam int LO    = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          s_valid, s_last, m_ready, m_valid, m_last, go_req, stop_req;
  logic [DW-1:0] s_data, m_data;
  logic          s_ready;

  logic auto_mode = 1'b0;
  logic man_ready = 1'b1, man_go = 1'b0, man_stop = 1'b0;
  logic drain_en  = 1'b0;
  int   fcnt = 0;
  int   cyc  = 0;
  int   checks = 0, fails = 0, mid_stops = 0;
  logic chk_en = 1'b0;
  logic exp_run = 1'b1;
  logic [DW:0] exp_q[$];

  always #5 clk = ~clk;

  assign m_ready  = auto_mode ? (fcnt < DEPTH) : man_ready;
  assign stop_req = auto_mode ? (fcnt >= HI)   : man_stop;
  assign go_req   = auto_mode ? (fcnt <= LO)   : man_go;

  axis_xon_gate #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
    .go_req(go_req), .stop_req(stop_req)
  );

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Downstream FIFO model: fills on output beats, drains slowly.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    fcnt <= fcnt + ((m_valid && m_ready) ? 1 : 0)
                 - ((drain_en && fcnt > 0 && (cyc % 3 == 0)) ? 1 : 0);
  end

  // Monitor / scoreboard (R9, R7 no loss or duplicate)
  always @(negedge clk) begin
    #2;
    if (chk_en && m_valid && m_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected beat", {31'd0, m_last, m_data}, 64'd0);
      end else begin
        logic [DW:0] e;
        e = exp_q.pop_front();
        check({m_last, m_data} == e, "R9 order/data", {31'd0, m_last, m_data}, {31'd0, e});
      end
    end
  end

  // Gate model checker (R3 R4 R5 R6 R8)
  always @(negedge clk) begin
    #2;
    if (chk_en) begin
      check(s_ready == (exp_run && (!m_valid || m_ready)), "R3 R4 R5 R6 R8 s_ready",
            {63'd0, s_ready}, {63'd0, exp_run && (!m_valid || m_ready)});
      if (auto_mode && !exp_run && fcnt > LO && fcnt < HI) mid_stops++;
      if (stop_req)    exp_run = 1'b0;
      else if (go_req) exp_run = 1'b1;
    end
  end

  task automatic send(input logic [DW-1:0] d, input logic l);
    s_valid = 1'b1; s_data = d; s_last = l;
    #1;
    while (!s_ready) begin @(negedge clk); #1; end
    exp_q.push_back({l, d});
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; s_valid = 1'b0; s_data = '0; s_last = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    check(m_valid == 1'b0, "R1 reset m_valid", {63'd0, m_valid}, 64'd0);
    check(s_ready == 1'b1, "R1 reset s_ready", {63'd0, s_ready}, 64'd1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    check(m_valid == 1'b0 && s_ready == 1'b1, "R1 after release", {62'd0, m_valid, s_ready}, 64'd1);
    exp_run = 1'b1;
    chk_en  = 1'b1;
    @(negedge clk);

    // R2: single beat latency with free downstream
    send(32'hA5A5_0001, 1'b0);
    #2;
    check(m_valid && m_data == 32'hA5A5_0001, "R2 latency", {31'd0, m_valid, m_data}, {31'd0, 1'b1, 32'hA5A5_0001});
    @(negedge clk);
    send(32'h0000_0002, 1'b0);
    send(32'h0000_0003, 1'b1);
    repeat (2) @(negedge clk);

    // R7/R8: hold a beat, stop the gate while it is held
    man_ready = 1'b0;
    send(32'hBEEF_0004, 1'b1);
    man_stop = 1'b1;
    @(negedge clk);
    man_stop = 1'b0;
    for (int i = 0; i < 4; i++) begin
      #2;
      check(m_valid && m_data == 32'hBEEF_0004 && m_last, "R7 held beat", {31'd0, m_valid, m_data}, {31'd0, 1'b1, 32'hBEEF_0004});
      @(negedge clk);
    end
    man_ready = 1'b1;
    @(negedge clk);
    #2;
    check(m_valid == 1'b0, "R7 delivered once", {63'd0, m_valid}, 64'd0);
    // R5: stopped, downstream free, ready stays low
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); #2;
      check(s_ready == 1'b0, "R5 stopped", {63'd0, s_ready}, 64'd0);
    end
    @(negedge clk);
    man_go = 1'b1;
    @(negedge clk);
    man_go = 1'b0;
    #2;
    check(s_ready == 1'b1, "R4 resume", {63'd0, s_ready}, 64'd1);

    // R6: both triggers at once
    @(negedge clk);
    man_go = 1'b1; man_stop = 1'b1;
    @(negedge clk);
    man_go = 1'b0; man_stop = 1'b0;
    #2;
    check(s_ready == 1'b0, "R6 stop wins", {63'd0, s_ready}, 64'd0);
    @(negedge clk);
    man_go = 1'b1;
    @(negedge clk);
    man_go = 1'b0;

    // Closed loop with the FIFO model
    auto_mode = 1'b1;
    drain_en  = 1'b1;
    for (int i = 0; i < 200; i++) send(32'h1000_0000 + i, (i % 8) == 7);
    repeat (400) @(negedge clk);
    check(mid_stops > 0, "R5 ready low between thresholds", mid_stops, 64'd1);
    check(exp_q.size() == 0, "R9 all beats delivered", exp_q.size(), 64'd0);
    finish_run();
  end
endmodule